// File: doc/BRIEF.md
# Converter Sample Transport Mapper

This block is the transmit-side transport stage of a multi-lane serial converter link. In each frame cycle it takes one flat bus word holding M converters × S samples of N bits, plus a small control field for every sample. Each sample becomes a 16-bit word: the sample sits in the upper bits, its control bits sit directly below, and zero padding fills the rest. These words are cut into octets, most significant octet first, and the octets are dealt out to L lanes, F consecutive octets to each lane.

Each lane leaves the block as 32-bit link words. When F is 1 or 2, several frames are collected into one link word. When F is 4 or more, one frame fills one or more link words. The input is a valid/ready stream and the output is a valid/ready stream. All lanes share one valid flag and move together.

Top module: `conv_transport_mapper`

## Requirements
- R1: Sample index k = m·S + s (converter m, sample s) occupies `smp_i[k*N +: N]`, and its control field occupies `ctl_i[k*CS +: CS]`, so converter 0 sample 0 is at the LSB.
- R2: Word k is 16 bits. The sample is in bits [15 -: N], the control field is directly below it in bits [15-N -: CS], and every remaining lower bit is 0.
- R3: Words are serialized in index order, each with its upper octet (bits 15:8) before its lower octet. This gives one octet stream per frame.
- R4: Lane l receives stream octets l·F to l·F+F−1, as its frame octets 0 to F−1.
- R5: When F < 4, 4/F consecutive accepted frames form one link word per lane. The earlier frame occupies the higher-order bits.
- R6: When F ≥ 4, each accepted frame yields F/4 link words per lane, emitted in octet order. In every link word the earliest octet is in bits [31:24], and lane l uses `lane_data_o[l*32 +: 32]`.
- R7: A frame is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is low only while a frame could not be absorbed without dropping an unsent link word. No link word is lost, duplicated or emitted spuriously.
- R8: While `lane_valid_o` is high and `lane_ready_i` is low, `lane_valid_o` and `lane_data_o` hold their values.
- R9: After the asynchronous reset `rst_ni`, `lane_valid_o` is 0 and `in_ready_o` is 1.
- R10: Elaboration fails unless F·8·L = M·S·16, N+CS ≤ 16, CS ≥ 1, and either F divides 4 or F is a multiple of 4.
- R11: With L = 4, the block works for F = 1 with (M,S) = (2,1) and (1,2), for F = 2 with M·S = 4, for F = 4 with M·S = 8, and for F = 8 with M·S = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | M*S*N | Sample bus, converter-major, sample 0 of converter 0 at the LSB |
| ctl_i | input | M*S*CS | Control bits, one CS-bit field per sample |
| in_valid_i | input | 1 | Frame present on the input |
| in_ready_o | output | 1 | Block can take a frame |
| lane_data_o | output | L*32 | Link word for every lane, lane l at bits l*32 |
| lane_valid_o | output | 1 | Link words valid on all lanes |
| lane_ready_i | input | 1 | Downstream takes the link words |

## Verification
The assertions check two things on every cycle. First, a stalled output holds its valid flag and data. Second, a new output word appears only after an accepted frame. In the gathering variant they also check that a full pending word blocks input, and in the splitting variant that an accepted frame is followed at once by a valid word. The octet ordering, the lane dealing, the tail padding and the frame-to-link-word packing can only be shown by the bench's scenarios. These compare every lane word against an independently computed octet stream, for five parameter sets, both with a free-running sink and with input gaps and output stalls.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int unsigned OCT_W  = 8;
  localparam int unsigned LINK_W = 32;

  typedef logic [OCT_W-1:0]  oct_t;
  typedef logic [LINK_W-1:0] link_word_t;

  function automatic bit cfg_ok(int unsigned l, int unsigned m, int unsigned s,
                                int unsigned n, int unsigned cs, int unsigned np,
                                int unsigned f);
    bit ok;
    ok = (np % OCT_W == 0) && (cs >= 1) && (n >= 1) && (n + cs <= np);
    ok = ok && (f * OCT_W * l == m * s * np);
    ok = ok && (f >= 1) && (((f < 4) && (4 % f == 0)) || (f % 4 == 0));
    return ok;
  endfunction
endpackage

// File: rtl/ctm_framer.sv
module ctm_framer
  import ctm_pkg::*;
#(
  parameter int unsigned L  = 4,
  parameter int unsigned M  = 2,
  parameter int unsigned S  = 1,
  parameter int unsigned N  = 14,
  parameter int unsigned CS = 1,
  parameter int unsigned NP = 16,
  parameter int unsigned F  = 1
) (
  input  logic [M*S*N-1:0]      smp_i,
  input  logic [M*S*CS-1:0]     ctl_i,
  output logic [L*F*OCT_W-1:0]  frame_o
);
  localparam int unsigned MS   = M * S;
  localparam int unsigned OPW  = NP / OCT_W;
  localparam int unsigned TOT  = MS * OPW;
  localparam int unsigned TAIL = NP - N - CS;

  logic [NP-1:0] word [MS];
  oct_t          oct  [TOT];

  for (genvar k = 0; k < MS; k++) begin : g_word
    if (TAIL > 0) begin : g_tail
      assign word[k] = {smp_i[k*N +: N], ctl_i[k*CS +: CS], {TAIL{1'b0}}};
    end else begin : g_notail
      assign word[k] = {smp_i[k*N +: N], ctl_i[k*CS +: CS]};
    end
  end

  // big-endian split: octet 0 of a word is its top octet
  for (genvar g = 0; g < TOT; g++) begin : g_oct
    assign oct[g] = word[g/OPW][NP-1-(g%OPW)*OCT_W -: OCT_W];
  end

  // lane slice holds frame octet 0 in its top bits
  for (genvar l = 0; l < L; l++) begin : g_lane
    for (genvar f = 0; f < F; f++) begin : g_fo
      assign frame_o[l*F*OCT_W + (F-1-f)*OCT_W +: OCT_W] = oct[l*F+f];
    end
  end
endmodule

// File: rtl/ctm_lane_packer.sv
module ctm_lane_packer
  import ctm_pkg::*;
#(
  parameter int unsigned L = 4,
  parameter int unsigned F = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [L*F*OCT_W-1:0]  frame_i,
  input  logic                  frame_valid_i,
  output logic                  frame_ready_o,
  output logic [L*LINK_W-1:0]   lane_data_o,
  output logic                  lane_valid_o,
  input  logic                  lane_ready_i
);
  localparam int unsigned FR_W   = F * OCT_W;
  localparam int unsigned LANE_W = L * LINK_W;

  logic in_fire, out_fire;
  assign in_fire  = frame_valid_i && frame_ready_o;
  assign out_fire = lane_valid_o && lane_ready_i;

  if (F < 4) begin : g_gather
    localparam int unsigned FPW = LINK_W / FR_W;
    localparam int unsigned CW  = $clog2(FPW);

    logic [CW-1:0]     cnt_q;
    logic [LANE_W-1:0] acc_q, shifted, out_q;
    logic              out_v_q, last_slot;

    assign last_slot = (cnt_q == CW'(FPW-1));

    for (genvar l = 0; l < L; l++) begin : g_sh
      assign shifted[l*LINK_W +: LINK_W] =
        {acc_q[l*LINK_W +: LINK_W-FR_W], frame_i[l*FR_W +: FR_W]};
    end

    assign frame_ready_o = !last_slot || !out_v_q || lane_ready_i;
    assign lane_valid_o  = out_v_q;
    assign lane_data_o   = out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q   <= '0;
        acc_q   <= '0;
        out_q   <= '0;
        out_v_q <= 1'b0;
      end else begin
        if (out_fire) out_v_q <= 1'b0;
        if (in_fire) begin
          acc_q <= shifted;
          if (last_slot) begin
            out_q   <= shifted;
            out_v_q <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_valid_o && !lane_ready_i && last_slot) |-> !frame_ready_o);
  end else begin : g_split
    localparam int unsigned WPF = FR_W / LINK_W;
    localparam int unsigned RW  = $clog2(WPF + 1);

    logic [RW-1:0]       rem_q;
    logic [L*FR_W-1:0]   hold_q, hold_shift;

    for (genvar l = 0; l < L; l++) begin : g_sh
      assign hold_shift[l*FR_W +: FR_W] = hold_q[l*FR_W +: FR_W] << LINK_W;
      assign lane_data_o[l*LINK_W +: LINK_W] = hold_q[l*FR_W + FR_W - LINK_W +: LINK_W];
    end

    assign lane_valid_o  = (rem_q != '0);
    assign frame_ready_o = (rem_q == '0) || ((rem_q == RW'(1)) && lane_ready_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rem_q  <= '0;
        hold_q <= '0;
      end else if (in_fire) begin
        hold_q <= frame_i;
        rem_q  <= RW'(WPF);
      end else if (out_fire) begin
        hold_q <= hold_shift;
        rem_q  <= rem_q - 1'b1;
      end
    end

    // R6
    frame_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_fire |=> lane_valid_o);
  end

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_valid_o && !lane_ready_i) |=> (lane_valid_o && $stable(lane_data_o)));

  // R7
  rise_from_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lane_valid_o) |-> $past(in_fire));
endmodule

// File: rtl/conv_transport_mapper.sv
module conv_transport_mapper
  import ctm_pkg::*;
#(
  parameter int unsigned L  = 4,
  parameter int unsigned M  = 2,
  parameter int unsigned S  = 1,
  parameter int unsigned N  = 14,
  parameter int unsigned CS = 1,
  parameter int unsigned F  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [M*S*N-1:0]     smp_i,
  input  logic [M*S*CS-1:0]    ctl_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  output logic [L*LINK_W-1:0]  lane_data_o,
  output logic                 lane_valid_o,
  input  logic                 lane_ready_i
);
  localparam int unsigned NP = 16;

  // R10
  if (!cfg_ok(L, M, S, N, CS, NP, F)) begin : g_cfg_bad
    $error("conv_transport_mapper: inconsistent L/M/S/N/CS/F");
  end

  logic [L*F*OCT_W-1:0] frame;

  ctm_framer #(.L(L), .M(M), .S(S), .N(N), .CS(CS), .NP(NP), .F(F)) u_framer (
    .smp_i   (smp_i),
    .ctl_i   (ctl_i),
    .frame_o (frame)
  );

  ctm_lane_packer #(.L(L), .F(F)) u_packer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_i       (frame),
    .frame_valid_i (in_valid_i),
    .frame_ready_o (in_ready_o),
    .lane_data_o   (lane_data_o),
    .lane_valid_o  (lane_valid_o),
    .lane_ready_i  (lane_ready_i)
  );
endmodule

// File: tb/conv_transport_mapper_tb.sv
module ctm_run #(
  parameter int unsigned L   = 4,
  parameter int unsigned M   = 2,
  parameter int unsigned S   = 1,
  parameter int unsigned N   = 14,
  parameter int unsigned CS  = 1,
  parameter int unsigned F   = 1,
  parameter int unsigned CFG = 0
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic done
);
  localparam int MS    = M * S;
  localparam int SW    = MS * N;
  localparam int CW    = MS * CS;
  localparam int NFR   = 8;
  localparam int NWORD = NFR * F / 4;

  logic [SW-1:0]     smp;
  logic [CW-1:0]     ctl;
  logic              in_valid, in_ready, lane_valid, lane_ready;
  logic [L*32-1:0]   lane_data;
  logic [SW-1:0]     fs [NFR];
  logic [CW-1:0]     fc [NFR];

  conv_transport_mapper #(.L(L), .M(M), .S(S), .N(N), .CS(CS), .F(F)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .ctl_i(ctl),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .lane_data_o(lane_data), .lane_valid_o(lane_valid), .lane_ready_i(lane_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL cfg%0d %s act=%h exp=%h", CFG, req, act, exp);
    end
  endtask

  // R1 R2 R3 R4: reference octet for frame fr, lane l, lane octet f
  function automatic logic [7:0] exp_oct(int fr, int l, int f);
    int g, k;
    logic [15:0] w;
    g = l * F + f;
    k = g / 2;
    w = '0;
    w[15 -: N]    = fs[fr][k*N +: N];
    w[15-N -: CS] = fc[fr][k*CS +: CS];
    return (g % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  // R5 R6: link word wi of lane l, earliest octet on top
  function automatic logic [31:0] exp_word(int wi, int l);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      int p;
      p = 4 * wi + b;
      r[31-8*b -: 8] = exp_oct(p / F, l, p % F);
    end
    return r;
  endfunction

  task automatic fill(input int seed);
    logic [31:0] st;
    st = 32'(seed) * 32'd2654435761 + 32'd7;
    for (int fr = 0; fr < NFR; fr++) begin
      for (int i = 0; i < SW; i++) begin
        st = st * 32'd1664525 + 32'd1013904223;
        fs[fr][i] = st[27];
      end
      for (int i = 0; i < CW; i++) begin
        st = st * 32'd1664525 + 32'd1013904223;
        ctl[0] = 1'b0;
        fc[fr][i] = st[29];
      end
    end
  endtask

  task automatic stream(input int gap_mod, input int bp_mod, input string tag);
    fork
      begin
        for (int fr = 0; fr < NFR; fr++) begin
          @(negedge clk);
          if (gap_mod != 0 && fr % gap_mod == 1) begin
            in_valid = 1'b0;
            @(negedge clk);
          end
          smp = fs[fr];
          ctl = fc[fr];
          in_valid = 1'b1;
          #1;
          while (!in_ready) begin
            @(negedge clk);
            #1;
          end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        int wi, cyc;
        bit stalled;
        logic [L*32-1:0] held;
        wi = 0; cyc = 0; stalled = 0; held = '0;
        while (wi < NWORD) begin
          @(negedge clk);
          lane_ready = (bp_mod == 0) || (cyc % bp_mod != 0);
          cyc++;
          #1;
          if (stalled) begin
            // R8: a stalled word stays put
            chk(lane_valid && lane_data == held, {tag, " R8 hold"}, lane_data[31:0], held[31:0]);
          end
          stalled = lane_valid && !lane_ready;
          held = lane_data;
          if (lane_valid && lane_ready) begin
            for (int l = 0; l < L; l++) begin
              logic [31:0] e;
              e = exp_word(wi, l);
              chk(lane_data[l*32 +: 32] == e, {tag, " R1 R2 R3 R4 R5 R6 R11 lane word"},
                  lane_data[l*32 +: 32], e);
            end
            wi++;
          end
        end
      end
    join
    repeat (3) @(negedge clk);
    #1;
    // R7: nothing beyond the expected words
    chk(!lane_valid, {tag, " R7 no extra word"}, 32'(lane_valid), 32'd0);
    chk(in_ready, {tag, " R7 ready when empty"}, 32'(in_ready), 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    // R9
    chk(!lane_valid, "R9 valid after reset", 32'(lane_valid), 32'd0);
    chk(in_ready, "R9 ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_free();
    fill(CFG * 11 + 1);
    stream(0, 0, "free");
  endtask

  task automatic t_backpressure();
    fill(CFG * 11 + 5);
    stream(3, 3, "bp");
    fill(CFG * 11 + 9);
    stream(0, 2, "bp2");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    in_valid = 1'b0; lane_ready = 1'b0; smp = '0; ctl = '0;
    @(posedge rst_n);
    t_reset();
    t_free();
    t_backpressure();
    done = 1'b1;
  end
endmodule

module conv_transport_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NRUN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NRUN-1:0] done;
  int chks [NRUN];
  int bads [NRUN];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctm_run #(.M(2), .S(1), .N(14), .CS(1), .F(1), .CFG(0)) u_run0 (clk, rst_n, chks[0], bads[0], done[0]);
  ctm_run #(.M(1), .S(2), .N(12), .CS(2), .F(1), .CFG(1)) u_run1 (clk, rst_n, chks[1], bads[1], done[1]);
  ctm_run #(.M(2), .S(2), .N(13), .CS(2), .F(2), .CFG(2)) u_run2 (clk, rst_n, chks[2], bads[2], done[2]);
  ctm_run #(.M(4), .S(2), .N(11), .CS(3), .F(4), .CFG(3)) u_run3 (clk, rst_n, chks[3], bads[3], done[3]);
  ctm_run #(.M(4), .S(4), .N(14), .CS(2), .F(8), .CFG(4)) u_run4 (clk, rst_n, chks[4], bads[4], done[4]);

  initial begin
    int tot, fail;
    bit timeout;
    timeout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      wait (&done);
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    tot = 0; fail = 0;
    for (int i = 0; i < NRUN; i++) begin
      tot += chks[i];
      fail += bads[i];
    end
    if (timeout) begin
      tot++;
      fail++;
      $display("FAIL R7 watchdog act=%h exp=%h", done, {NRUN{1'b1}});
    end
    $display("[TB] %0d tests run, %0d failed", tot, fail);
    $finish;
  end
endmodule